// File: doc/BRIEF.md
# PCI Target Address and Command Decoder

This block watches the address phase of a 32-bit PCI bus. It decides whether an I/O or memory transaction targets a device that owns one 256-byte register window. The configuration block supplies two base values, one for I/O space and one for memory space, along with an enable bit for each space. On the first clock where FRAME# is sampled low while the bus is idle, the decoder samples the address and the command nibble. It classifies the command and compares the upper address bits with the base value of the matching space. From the next clock it presents a claim strobe, the space that was hit, a read/write flag and a register offset. These outputs stay steady for the whole transaction.

Both windows lead to one register file. The register set appears twice inside the window: address bit 7 is dropped, so the lower and upper 128-byte halves select the same registers. While a claim is active, the data-phase byte enables from the bus are passed through active-high next to the offset.

The control is a three-state machine:

- **ST_IDLE** is the bus-free state.
- **ST_CLAIMED** holds a transaction that hit.
- **ST_PASSED** holds a transaction that belongs to another agent.

The transitions are:

- **GO_CLAIM**: ST_IDLE to ST_CLAIMED, when FRAME# is low and the decode hits.
- **GO_PASS**: ST_IDLE to ST_PASSED, when FRAME# is low and the decode misses.
- **END_CLAIM**: ST_CLAIMED to ST_IDLE, when FRAME# and IRDY# are both high.
- **END_PASS**: ST_PASSED to ST_IDLE, under the same condition.
- In every other case the state holds.

Top module: `pci_tgt_addr_dec`

## Requirements
- R1: After reset, `hit` is 0 and `byte_en` is 0.
- R2: Command codes are classified as follows, with `is_write` equal to 1 for the write codes:
  - 4'b0010 is an I/O read.
  - 4'b0011 is an I/O write.
  - 4'b0110, 4'b1100 and 4'b1110 are memory reads.
  - 4'b0111 and 4'b1111 are memory writes.
- R3: Every other command code never produces a hit. This includes the configuration codes 4'b1010 and 4'b1011.
- R4: An I/O command hits only when `ad[31:8]` equals `io_base`. A memory command hits only when `ad[31:8]` equals `mem_base`. A difference in any one of those 24 bits is a miss.
- R5: An I/O command never hits while `io_space_en` is 0. A memory command never hits while `mem_space_en` is 0.
- R6: On a hit, `reg_off` equals `ad[6:0]` from the address phase. Address bit 7 has no effect on it.
- R7: The decode of the address phase appears on `hit`, `space_io`, `is_write` and `reg_off` one clock after the edge that first samples FRAME# low in ST_IDLE. It is not visible earlier.
- R8: `hit`, `space_io`, `is_write` and `reg_off` stay stable whatever `ad` and `cbe_n` do. They hold until an edge samples FRAME# and IRDY# both high, and `hit` is 0 after that edge.
- R9: `byte_en` equals `~cbe_n` while `hit` is 1 and is 0 otherwise.
- R10: On a hit, `space_io` is 1 for an I/O command and 0 for a memory command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| frame_n | input | 1 | FRAME#, active low |
| irdy_n | input | 1 | IRDY#, active low |
| ad | input | 32 | Address/data bus |
| cbe_n | input | 4 | Command / byte enables, active low |
| io_base | input | 24 | I/O window base, address bits 31:8 |
| mem_base | input | 24 | Memory window base, address bits 31:8 |
| io_space_en | input | 1 | I/O space decode enable |
| mem_space_en | input | 1 | Memory space decode enable |
| hit | output | 1 | Transaction claimed |
| space_io | output | 1 | 1 = I/O window, 0 = memory window |
| is_write | output | 1 | Claimed transaction is a write |
| reg_off | output | 7 | Register offset, bit 7 folded away |
| byte_en | output | 4 | Active-high byte enables while claimed |

## Verification
The bench builds the decoder with its default parameters: a 32-bit address and a 256-byte window. With those values the 24-bit base compare, the 7-bit mirrored offset and the full 16-code command space are all exercised. Random addresses are drawn near each base, with single-bit upsets at the ends of the compared field. Random command codes include the configuration codes. Together these reach the miss edges of the compare, the bit-7 mirror, and the enable gating that the default width makes observable.

// File: rtl/pcid_pkg.sv
package pcid_pkg;

    localparam int CMD_W = 4;

    localparam logic [CMD_W-1:0] CMD_IO_RD   = 4'b0010;
    localparam logic [CMD_W-1:0] CMD_IO_WR   = 4'b0011;
    localparam logic [CMD_W-1:0] CMD_MEM_RD  = 4'b0110;
    localparam logic [CMD_W-1:0] CMD_MEM_WR  = 4'b0111;
    localparam logic [CMD_W-1:0] CMD_MEM_RDM = 4'b1100;
    localparam logic [CMD_W-1:0] CMD_MEM_RDL = 4'b1110;
    localparam logic [CMD_W-1:0] CMD_MEM_WRI = 4'b1111;

    typedef enum logic [1:0] {
        SPC_NONE = 2'd0,
        SPC_IO   = 2'd1,
        SPC_MEM  = 2'd2
    } space_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_CLAIMED = 2'd1,
        ST_PASSED  = 2'd2
    } dec_state_e;

    typedef struct packed {
        space_e space;
        logic   wr;
    } cmd_info_t;

    localparam int NUM_SPACES = 2;
    localparam int IDX_IO     = 0;
    localparam int IDX_MEM    = 1;

endpackage

// File: rtl/pcid_cmd_class.sv
module pcid_cmd_class
    import pcid_pkg::*;
(
    input  logic [CMD_W-1:0] cmd,
    output cmd_info_t        info
);

    always_comb begin
        info.space = SPC_NONE;
        info.wr    = 1'b0;
        unique case (cmd)
            CMD_IO_RD: begin
                info.space = SPC_IO;
                info.wr    = 1'b0;
            end
            CMD_IO_WR: begin
                info.space = SPC_IO;
                info.wr    = 1'b1;
            end
            CMD_MEM_RD, CMD_MEM_RDM, CMD_MEM_RDL: begin
                info.space = SPC_MEM;
                info.wr    = 1'b0;
            end
            CMD_MEM_WR, CMD_MEM_WRI: begin
                info.space = SPC_MEM;
                info.wr    = 1'b1;
            end
            default: begin
                info.space = SPC_NONE;
                info.wr    = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/pcid_win_match.sv
module pcid_win_match #(
    parameter int BASE_W = 24
) (
    input  logic              space_en,
    input  logic              space_sel,
    input  logic [BASE_W-1:0] base,
    input  logic [BASE_W-1:0] addr_hi,
    output logic              match
);

    logic same;

    always_comb begin
        same  = (addr_hi == base);
        match = space_en & space_sel & same;
    end

endmodule

// File: rtl/pcid_fsm.sv
module pcid_fsm
    import pcid_pkg::*;
#(
    parameter int OFF_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_n,
    input  logic             irdy_n,
    input  logic             dec_hit,
    input  logic             dec_io,
    input  logic             dec_wr,
    input  logic [OFF_W-1:0] dec_off,
    output logic             hit,
    output logic             space_io,
    output logic             is_write,
    output logic [OFF_W-1:0] reg_off
);

    dec_state_e state_q, state_d;
    logic       addr_phase;
    logic       bus_free;

    always_comb begin
        addr_phase = (state_q == ST_IDLE) && !frame_n;
        bus_free   = frame_n && irdy_n;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!frame_n) begin
                    state_d = dec_hit ? ST_CLAIMED : ST_PASSED;
                end
            end
            ST_CLAIMED: begin
                if (bus_free) begin
                    state_d = ST_IDLE;
                end
            end
            ST_PASSED: begin
                if (bus_free) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // captured decode outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            space_io <= 1'b0;
            is_write <= 1'b0;
            reg_off  <= '0;
        end else if (addr_phase) begin
            space_io <= dec_io;
            is_write <= dec_wr;
            reg_off  <= dec_off;
        end
    end

    always_comb begin
        hit = (state_q == ST_CLAIMED);
    end

endmodule

// File: rtl/pci_tgt_addr_dec.sv
module pci_tgt_addr_dec
    import pcid_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int WIN_BITS = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       frame_n,
    input  logic                       irdy_n,
    input  logic [ADDR_W-1:0]          ad,
    input  logic [CMD_W-1:0]           cbe_n,
    input  logic [ADDR_W-WIN_BITS-1:0] io_base,
    input  logic [ADDR_W-WIN_BITS-1:0] mem_base,
    input  logic                       io_space_en,
    input  logic                       mem_space_en,
    output logic                       hit,
    output logic                       space_io,
    output logic                       is_write,
    output logic [WIN_BITS-2:0]        reg_off,
    output logic [CMD_W-1:0]           byte_en
);

    localparam int BASE_W = ADDR_W - WIN_BITS;
    localparam int OFF_W  = WIN_BITS - 1;

    cmd_info_t                  info;
    logic [BASE_W-1:0]          addr_hi;
    logic [OFF_W-1:0]           off_now;
    logic [NUM_SPACES-1:0]      sp_match;
    logic [NUM_SPACES-1:0]      sp_en;
    logic [NUM_SPACES-1:0]      sp_sel;
    logic [NUM_SPACES-1:0][BASE_W-1:0] sp_base;
    logic                       dec_hit;

    always_comb begin
        addr_hi          = ad[ADDR_W-1:WIN_BITS];
        off_now          = ad[OFF_W-1:0];
        sp_en[IDX_IO]    = io_space_en;
        sp_en[IDX_MEM]   = mem_space_en;
        sp_sel[IDX_IO]   = (info.space == SPC_IO);
        sp_sel[IDX_MEM]  = (info.space == SPC_MEM);
        sp_base[IDX_IO]  = io_base;
        sp_base[IDX_MEM] = mem_base;
        dec_hit          = |sp_match;
    end

    pcid_cmd_class u_class (
        .cmd  (cbe_n),
        .info (info)
    );

    for (genvar g = 0; g < NUM_SPACES; g++) begin : g_win
        pcid_win_match #(.BASE_W(BASE_W)) u_match (
            .space_en  (sp_en[g]),
            .space_sel (sp_sel[g]),
            .base      (sp_base[g]),
            .addr_hi   (addr_hi),
            .match     (sp_match[g])
        );
    end

    pcid_fsm #(.OFF_W(OFF_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_n  (frame_n),
        .irdy_n   (irdy_n),
        .dec_hit  (dec_hit),
        .dec_io   (sp_sel[IDX_IO]),
        .dec_wr   (info.wr),
        .dec_off  (off_now),
        .hit      (hit),
        .space_io (space_io),
        .is_write (is_write),
        .reg_off  (reg_off)
    );

    always_comb begin
        byte_en = hit ? ~cbe_n : '0;
    end

endmodule

// File: rtl/pcid_checker.sv
module pcid_checker #(
    parameter int OFF_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_n,
    input logic             irdy_n,
    input logic [3:0]       cbe_n,
    input logic             io_space_en,
    input logic             mem_space_en,
    input logic             hit,
    input logic             space_io,
    input logic             is_write,
    input logic [OFF_W-1:0] reg_off,
    input logic [3:0]       byte_en
);

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !hit);  // R1

    AST_NO_CFG_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hit) |-> $past(cbe_n[3:1] != 3'b101));  // R3

    AST_IO_CMD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(hit) && space_io) |-> $past(cbe_n[3:1] == 3'b001));  // R10

    AST_WRITE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hit) |-> (is_write == $past(cbe_n[0])));  // R2

    AST_IO_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(hit) && space_io) |-> $past(io_space_en));  // R5

    AST_MEM_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(hit) && !space_io) |-> $past(mem_space_en));  // R5

    AST_CLAIM_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hit) |-> $past(!frame_n));  // R7

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && $past(hit)) |-> ($stable(reg_off) && $stable(is_write) && $stable(space_io)));  // R8

    AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(frame_n) && $past(irdy_n)) |-> !hit);  // R8

    AST_BE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (byte_en == 4'b0000));  // R9

endmodule

bind pci_tgt_addr_dec pcid_checker #(.OFF_W(WIN_BITS-1)) u_chk (.*);

// File: tb/test_pci_tgt_addr_dec.sv
`timescale 1ns/1ps
module test_pci_tgt_addr_dec;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_n = 1'b1;
    logic        irdy_n = 1'b1;
    logic [31:0] ad = '0;
    logic [3:0]  cbe_n = 4'hF;
    logic [23:0] io_base = 24'h001234;
    logic [23:0] mem_base = 24'hC0FFEE;
    logic        io_space_en = 1'b1;
    logic        mem_space_en = 1'b1;
    logic        hit, space_io, is_write;
    logic [6:0]  reg_off;
    logic [3:0]  byte_en;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pci_tgt_addr_dec i_pci_tgt_addr_dec (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
        .ad(ad), .cbe_n(cbe_n), .io_base(io_base), .mem_base(mem_base),
        .io_space_en(io_space_en), .mem_space_en(mem_space_en),
        .hit(hit), .space_io(space_io), .is_write(is_write),
        .reg_off(reg_off), .byte_en(byte_en)
    );

    function automatic int cls(input logic [3:0] c); // 0 none, 1 io, 2 mem
        case (c)
            4'b0010, 4'b0011: return 1;
            4'b0110, 4'b0111, 4'b1100, 4'b1110, 4'b1111: return 2;
            default: return 0;
        endcase
    endfunction

    function automatic bit exp_hit(input logic [31:0] a, input logic [3:0] c);
        int k = cls(c);
        if (k == 1) return io_space_en && (a[31:8] == io_base);
        if (k == 2) return mem_space_en && (a[31:8] == mem_base);
        return 1'b0;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic txn(input logic [31:0] a, input logic [3:0] c, input logic [3:0] be,
                       input string req);
        bit h;
        logic [6:0] off;
        h = exp_hit(a, c);
        off = a[6:0];
        @(negedge clk);
        frame_n = 1'b0; irdy_n = 1'b1; ad = a; cbe_n = c;
        #1 chk({"R7 early ", req}, hit, 0);
        @(negedge clk);
        frame_n = 1'b1; irdy_n = 1'b0; ad = $urandom; cbe_n = ~be;
        #1;
        chk({"R4 hit ", req}, hit, h);
        chk({"R9 be ", req}, byte_en, h ? be : 4'b0);
        if (h) begin
            chk({"R6 off ", req}, reg_off, off);
            chk({"R2 wr ", req}, is_write, c[0]);
            chk({"R10 io ", req}, space_io, cls(c) == 1);
        end
        @(negedge clk);
        ad = $urandom; cbe_n = $urandom;
        #1;
        chk({"R8 hold ", req}, hit, h);
        if (h) chk({"R8 off ", req}, reg_off, off);
        @(negedge clk);
        frame_n = 1'b1; irdy_n = 1'b1; cbe_n = 4'hF;
        @(negedge clk);
        #1 chk({"R8 release ", req}, hit, 0);
        chk({"R9 idle ", req}, byte_en, 0);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] a;
        logic [3:0]  c;
        void'($urandom(32'd1234));
        #1;
        chk("R1 reset hit", hit, 0);
        chk("R1 reset be", byte_en, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", hit, 0);

        // R2 every hitting code
        txn({io_base, 8'h05}, 4'b0010, 4'hF, "R2 IO rd");
        txn({io_base, 8'h7A}, 4'b0011, 4'h3, "R2 IO wr");
        txn({mem_base, 8'h11}, 4'b0110, 4'h1, "R2 MR");
        txn({mem_base, 8'h12}, 4'b0111, 4'h8, "R2 MW");
        txn({mem_base, 8'h13}, 4'b1100, 4'hC, "R2 MRM");
        txn({mem_base, 8'h14}, 4'b1110, 4'h6, "R2 MRL");
        txn({mem_base, 8'h15}, 4'b1111, 4'hA, "R2 MWI");
        // R6 mirror: bit 7 set
        txn({mem_base, 8'h85}, 4'b0110, 4'hF, "R6 upper half");
        txn({io_base, 8'hFF}, 4'b0010, 4'hF, "R6 top");
        // R3 config and other codes with matching address
        txn({io_base, 8'h04}, 4'b1010, 4'hF, "R3 cfg rd");
        txn({mem_base, 8'h04}, 4'b1011, 4'hF, "R3 cfg wr");
        txn({mem_base, 8'h04}, 4'b0000, 4'hF, "R3 code0");
        // R4 wrong space base and single-bit misses
        txn({mem_base, 8'h04}, 4'b0010, 4'hF, "R4 io vs mem base");
        txn({io_base ^ 24'h000001, 8'h04}, 4'b0011, 4'hF, "R4 bit8");
        txn({mem_base ^ 24'h800000, 8'h04}, 4'b0110, 4'hF, "R4 bit31");
        // R5 enables
        io_space_en = 1'b0;
        txn({io_base, 8'h04}, 4'b0010, 4'hF, "R5 io off");
        txn({mem_base, 8'h04}, 4'b0110, 4'hF, "R5 mem still on");
        io_space_en = 1'b1; mem_space_en = 1'b0;
        txn({mem_base, 8'h04}, 4'b0111, 4'hF, "R5 mem off");
        txn({io_base, 8'h04}, 4'b0011, 4'hF, "R5 io still on");
        mem_space_en = 1'b1;

        // random
        for (int i = 0; i < 400; i++) begin
            if (i % 50 == 0) begin
                io_base = $urandom; mem_base = $urandom;
                io_space_en = ($urandom % 4) != 0;
                mem_space_en = ($urandom % 4) != 0;
            end
            c = $urandom;
            a = $urandom;
            case ($urandom % 4)
                0: a[31:8] = io_base;
                1: a[31:8] = mem_base;
                2: a[31:8] = mem_base ^ (24'h1 << ($urandom % 24));
                default: ;
            endcase
            txn(a, c, $urandom, "rand");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule